// File: doc/BRIEF.md
# Cartridge Bank Mapper with Nametable Mirroring

This block sits beside a game-console CPU and its picture processor and widens their small address spaces onto larger external memories. CPU writes landing in the upper half of the CPU map are decoded into a set of bank-number registers and a two-bit screen-layout mode. Three translators then run in parallel and without a clock. One turns a CPU read address into a program ROM address. One turns a picture-bus pattern address into a pattern ROM address. The third folds a nametable address into the 2 KB internal video RAM.

Program space is split into four 8 KB windows. The lower three each take a bank number that software writes, and the top window is fixed to the last page. Pattern space is split into eight 1 KB windows, each with its own bank number. The mode register picks one of four ways to fold the four logical nametables onto the two physical pages.

The register decode looks only at address bits 15:12 and bit 4, so every register also appears at many other addresses. Writes to the sound-chip ports, and to any other location in the decoded range that has no register, leave the mapper unchanged.

Top module: `cart_bank_mapper`

## Requirements
- R1: A synchronous active-high reset sets every program bank, every pattern bank and the mode register to zero.
- R2: With the write strobe high, a write at region 0x8 with bit 4 clear, region 0x8 with bit 4 set, or region 0x9 with bit 4 clear loads the 8-bit bank for the CPU window at 0x8000, 0xA000 or 0xC000 respectively. For an address with bit 15 set and bits 14:13 not both one, the program address is bank * 0x2000 + address[12:0].
- R3: CPU addresses 0xE000 to 0xFFFF always translate with bank 0xFF, so program address bits 20:13 are all ones.
- R4: CPU addresses below 0x8000 translate with bank 0, so the program address equals address[12:0].
- R5: Writes at regions 0xA, 0xB, 0xC and 0xD, with bit 4 clear and then set within each region, load pattern banks 0 to 7 in that order. The pattern address is bank[ppu_addr[12:10]] * 0x400 + ppu_addr[9:0].
- R6: A write at region 0xE with bit 4 clear loads the mode register from data bits 1:0.
- R7: The video RAM address is {page, ppu_addr[9:0]}. The page is ppu_addr[10] in mode 0, ppu_addr[11] in mode 1, 0 in mode 2 and 1 in mode 3.
- R8: Writes at region 0x9 with bit 4 set (the sound ports, such as 0x9010 and 0x9030), at region 0xE with bit 4 set, at region 0xF, and below 0x8000 change no mapper state.
- R9: Only write-address bits 15:12 and bit 4 take part in decode, so 0x8ACF reaches program bank 0, 0xDFFF reaches pattern bank 7 and 0xE7E3 reaches the mode register.
- R10: A register changes only on a clock edge where the strobe is high. Its new value is visible at the translator outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_addr | input | 16 | CPU address to translate |
| prg_rom_addr | output | 21 | Program ROM address |
| ppu_addr | input | 14 | Picture-bus address |
| chr_rom_addr | output | 18 | Pattern ROM address |
| vram_addr | output | 11 | Internal video RAM address |

## Verification
All three translators are combinational from the registers. A wrong bank value or mode therefore shows on the affected output bits in the first sample after the faulty write edge, but only while the probing address selects that window or falls in that nametable quadrant. For this reason the bench sweeps every pattern address, every nametable address in each mode, and a dense stride of CPU addresses after each group of writes, so a corrupted register cannot stay hidden. A decode fault, such as a wrong register being hit or an ignored port being written, shows up as a changed window in the next sweep, with the region named in the failing requirement.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int CPU_AW      = 16;
  localparam int PPU_AW      = 14;
  localparam int PRG_PAGE_W  = 13;
  localparam int CHR_PAGE_W  = 10;
  localparam int NT_PAGE_W   = 10;
  localparam int PRG_WINDOWS = 3;
  localparam int CHR_WINDOWS = 8;
  localparam int CHR_IDX_W   = $clog2(CHR_WINDOWS);

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_PRG    = 2'd1,
    TGT_CHR    = 2'd2,
    TGT_LAYOUT = 2'd3
  } wr_target_e;

  typedef enum logic [1:0] {
    LAYOUT_SIDE   = 2'd0,
    LAYOUT_STACK  = 2'd1,
    LAYOUT_SOLO_A = 2'd2,
    LAYOUT_SOLO_B = 2'd3
  } layout_e;

endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         wr_en,
  input  logic [CPU_AW-1:0]                            wr_addr,
  input  logic [7:0]                                   wr_data,
  output logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0]       prg_bank,
  output logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0]       chr_bank,
  output logic [1:0]                                   layout
);

  logic [3:0]           region;
  logic                 sub;
  wr_target_e           target;
  logic [1:0]           prg_idx;
  logic [CHR_IDX_W-1:0] chr_idx;
  logic [3:0]           region_off;
  logic                 unused_addr_bits;

  assign region           = wr_addr[15:12];
  assign sub              = wr_addr[4];
  assign region_off       = region - 4'hA;
  assign unused_addr_bits = ^{wr_addr[11:5], wr_addr[3:0]};

  always_comb begin
    target  = TGT_NONE;
    prg_idx = 2'd0;
    chr_idx = '0;
    case (region)
      4'h8: begin
        target  = TGT_PRG;
        prg_idx = {1'b0, sub};
      end
      4'h9: begin
        if (!sub) begin
          target  = TGT_PRG;
          prg_idx = 2'd2;
        end
      end
      4'hA, 4'hB, 4'hC, 4'hD: begin
        target  = TGT_CHR;
        chr_idx = {region_off[1:0], sub};
      end
      4'hE: begin
        if (!sub) target = TGT_LAYOUT;
      end
      default: target = TGT_NONE;
    endcase
  end

  for (genvar i = 0; i < PRG_WINDOWS; i++) begin : g_prg
    always_ff @(posedge clk) begin
      if (rst)
        prg_bank[i] <= '0;
      else if (wr_en && target == TGT_PRG && prg_idx == 2'(i))
        prg_bank[i] <= PRG_BANK_W'(wr_data);
    end
  end

  for (genvar j = 0; j < CHR_WINDOWS; j++) begin : g_chr
    always_ff @(posedge clk) begin
      if (rst)
        chr_bank[j] <= '0;
      else if (wr_en && target == TGT_CHR && chr_idx == CHR_IDX_W'(j))
        chr_bank[j] <= CHR_BANK_W'(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      layout <= LAYOUT_SIDE;
    else if (wr_en && target == TGT_LAYOUT)
      layout <= wr_data[1:0];
  end

endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8
) (
  input  logic [CPU_AW-1:0]                      cpu_addr,
  input  logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0] prg_bank,
  output logic [PRG_BANK_W+PRG_PAGE_W-1:0]       rom_addr
);

  logic [PRG_BANK_W-1:0] bank;

  always_comb begin
    if (!cpu_addr[15]) begin
      bank = '0;
    end else begin
      case (cpu_addr[14:13])
        2'd0:    bank = prg_bank[0];
        2'd1:    bank = prg_bank[1];
        2'd2:    bank = prg_bank[2];
        default: bank = '1;
      endcase
    end
  end

  assign rom_addr = {bank, cpu_addr[PRG_PAGE_W-1:0]};

endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate
  import mapper_pkg::*;
#(
  parameter int CHR_BANK_W = 8
) (
  input  logic [PPU_AW-1:0]                      ppu_addr,
  input  logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0] chr_bank,
  output logic [CHR_BANK_W+CHR_PAGE_W-1:0]       rom_addr
);

  logic [CHR_IDX_W-1:0] win;
  logic                 unused_hi;

  assign win       = ppu_addr[CHR_PAGE_W +: CHR_IDX_W];
  assign unused_hi = ^ppu_addr[PPU_AW-1:CHR_PAGE_W+CHR_IDX_W];
  assign rom_addr  = {chr_bank[win], ppu_addr[CHR_PAGE_W-1:0]};

endmodule

// File: rtl/mapper_nt_fold.sv
module mapper_nt_fold
  import mapper_pkg::*;
(
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic [1:0]        layout,
  output logic [NT_PAGE_W:0] vram_addr
);

  logic page;
  logic unused_hi;

  assign unused_hi = ^ppu_addr[PPU_AW-1:12];

  always_comb begin
    case (layout_e'(layout))
      LAYOUT_SIDE:   page = ppu_addr[10];
      LAYOUT_STACK:  page = ppu_addr[11];
      LAYOUT_SOLO_A: page = 1'b0;
      default:       page = 1'b1;
    endcase
  end

  assign vram_addr = {page, ppu_addr[NT_PAGE_W-1:0]};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cpu_wr,
  input  logic [15:0]                        cpu_wr_addr,
  input  logic [7:0]                         cpu_wr_data,
  input  logic [15:0]                        cpu_rd_addr,
  output logic [PRG_BANK_W+PRG_PAGE_W-1:0]   prg_rom_addr,
  input  logic [13:0]                        ppu_addr,
  output logic [CHR_BANK_W+CHR_PAGE_W-1:0]   chr_rom_addr,
  output logic [NT_PAGE_W:0]                 vram_addr
);

  logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0] prg_bank_q;
  logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0] chr_bank_q;
  logic [1:0]                             layout_q;

  mapper_regfile #(
    .PRG_BANK_W(PRG_BANK_W),
    .CHR_BANK_W(CHR_BANK_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cpu_wr),
    .wr_addr  (cpu_wr_addr),
    .wr_data  (cpu_wr_data),
    .prg_bank (prg_bank_q),
    .chr_bank (chr_bank_q),
    .layout   (layout_q)
  );

  mapper_prg_xlate #(
    .PRG_BANK_W(PRG_BANK_W)
  ) u_prg (
    .cpu_addr (cpu_rd_addr),
    .prg_bank (prg_bank_q),
    .rom_addr (prg_rom_addr)
  );

  mapper_chr_xlate #(
    .CHR_BANK_W(CHR_BANK_W)
  ) u_chr (
    .ppu_addr (ppu_addr),
    .chr_bank (chr_bank_q),
    .rom_addr (chr_rom_addr)
  );

  mapper_nt_fold u_nt (
    .ppu_addr  (ppu_addr),
    .layout    (layout_q),
    .vram_addr (vram_addr)
  );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 8
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   cpu_wr,
  input logic [15:0]                            cpu_wr_addr,
  input logic [7:0]                             cpu_wr_data,
  input logic [15:0]                            cpu_rd_addr,
  input logic [PRG_BANK_W+PRG_PAGE_W-1:0]       prg_rom_addr,
  input logic [13:0]                            ppu_addr,
  input logic [CHR_BANK_W+CHR_PAGE_W-1:0]       chr_rom_addr,
  input logic [NT_PAGE_W:0]                     vram_addr,
  input logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0] prg_bank_q,
  input logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0] chr_bank_q,
  input logic [1:0]                             layout_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prg_bank_q == '0 && chr_bank_q == '0 && layout_q == 2'd0));

  // R3
  top_window_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_addr[15:13] == 3'b111) |-> (prg_rom_addr[PRG_BANK_W+PRG_PAGE_W-1:PRG_PAGE_W] == '1));

  // R5
  chr_offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    chr_rom_addr[CHR_PAGE_W-1:0] == ppu_addr[CHR_PAGE_W-1:0]);

  // R6
  layout_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_wr_addr[15:12] == 4'hE && !cpu_wr_addr[4]) |=> (layout_q == $past(cpu_wr_data[1:0])));

  // R7
  solo_page_chk: assert property (@(posedge clk) disable iff (rst)
    (layout_q[1]) |-> (vram_addr[NT_PAGE_W] == layout_q[0]));

  // R8
  sound_port_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_wr_addr[15:12] == 4'h9 && cpu_wr_addr[4])
      |=> ($stable(prg_bank_q) && $stable(chr_bank_q) && $stable(layout_q)));

  // R10
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr) |=> ($stable(prg_bank_q) && $stable(chr_bank_q) && $stable(layout_q)));

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .PRG_BANK_W(PRG_BANK_W),
  .CHR_BANK_W(CHR_BANK_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr       (cpu_wr),
  .cpu_wr_addr  (cpu_wr_addr),
  .cpu_wr_data  (cpu_wr_data),
  .cpu_rd_addr  (cpu_rd_addr),
  .prg_rom_addr (prg_rom_addr),
  .ppu_addr     (ppu_addr),
  .chr_rom_addr (chr_rom_addr),
  .vram_addr    (vram_addr),
  .prg_bank_q   (prg_bank_q),
  .chr_bank_q   (chr_bank_q),
  .layout_q     (layout_q)
);

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wr_addr = '0;
  logic [7:0]  cpu_wr_data = '0;
  logic [15:0] cpu_rd_addr = '0;
  logic [13:0] ppu_addr = '0;
  logic [20:0] prg_rom_addr;
  logic [17:0] chr_rom_addr;
  logic [10:0] vram_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_prg [3];
  logic [7:0] m_chr [8];
  logic [1:0] m_mode;

  always #5 clk = ~clk;

  cart_bank_mapper u0 (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr       (cpu_wr),
    .cpu_wr_addr  (cpu_wr_addr),
    .cpu_wr_data  (cpu_wr_data),
    .cpu_rd_addr  (cpu_rd_addr),
    .prg_rom_addr (prg_rom_addr),
    .ppu_addr     (ppu_addr),
    .chr_rom_addr (chr_rom_addr),
    .vram_addr    (vram_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) m_prg[i] = 8'h00;
    for (int i = 0; i < 8; i++) m_chr[i] = 8'h00;
    m_mode = 2'd0;
  endtask

  // decode from R2, R5, R6, R8, R9
  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] r;
    r = a[15:12];
    if (r == 4'h8) m_prg[a[4]] = d;
    else if (r == 4'h9 && !a[4]) m_prg[2] = d;
    else if (r >= 4'hA && r <= 4'hD) m_chr[{r - 4'hA, 1'b0} + 4'(a[4])] = d;
    else if (r == 4'hE && !a[4]) m_mode = d[1:0];
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
  endtask

  task automatic sweep_prg(input string req, input int step);
    for (int a = 0; a < 65536; a += step) begin
      logic [7:0] b;
      string t;
      cpu_rd_addr = 16'(a);
      #1;
      if (a < 16'h8000) begin b = 8'h00; t = "R4"; end
      else if (a >= 16'hE000) begin b = 8'hFF; t = "R3"; end
      else begin b = m_prg[(a - 16'h8000) / 16'h2000]; t = req; end
      chk(t, int'(prg_rom_addr), b * 32'h2000 + (a % 32'h2000));
    end
  endtask

  task automatic sweep_chr(input string req);
    for (int p = 0; p < 8192; p++) begin
      ppu_addr = 14'(p);
      #1;
      chk(req, int'(chr_rom_addr), m_chr[p / 1024] * 32'h400 + (p % 1024));
    end
  endtask

  task automatic sweep_nt(input string req);
    for (int p = 16'h2000; p < 16'h3000; p++) begin
      int page;
      ppu_addr = 14'(p);
      #1;
      case (m_mode)
        2'd0: page = (p / 1024) % 2;
        2'd1: page = (p / 2048) % 2;
        2'd2: page = 0;
        default: page = 1;
      endcase
      chk(req, int'(vram_addr), page * 1024 + (p % 1024));
    end
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    sweep_prg("R1", 251);
    sweep_chr("R1");
    sweep_nt("R1");

    // R2: program banks via canonical addresses
    wr(16'h8000, 8'h15);
    wr(16'h8010, 8'hA3);
    wr(16'h9000, 8'h7E);
    sweep_prg("R2", 3);

    // R5: pattern banks in order
    wr(16'hA000, 8'h11); wr(16'hA010, 8'h22);
    wr(16'hB000, 8'h33); wr(16'hB010, 8'h44);
    wr(16'hC000, 8'h55); wr(16'hC010, 8'h66);
    wr(16'hD000, 8'h77); wr(16'hD010, 8'hF8);
    sweep_chr("R5");

    // R6, R7: each layout mode
    for (int m = 0; m < 4; m++) begin
      wr(16'hE000, 8'hFC | 8'(m));
      sweep_nt("R7");
      chk("R6", int'(vram_addr[10]), (m == 2) ? 0 : 1);
    end

    // R8: ignored locations
    wr(16'h9010, 8'hFF);
    wr(16'h9030, 8'h01);
    wr(16'hE010, 8'h02);
    wr(16'hF000, 8'h07);
    wr(16'hF010, 8'h00);
    wr(16'h7000, 8'hEE);
    wr(16'h0000, 8'h99);
    sweep_prg("R8", 5);
    sweep_chr("R8");
    sweep_nt("R8");

    // R9: aliased decode
    wr(16'h8ACF, 8'h3C);
    wr(16'hDFFF, 8'h05);
    wr(16'hE7E3, 8'h01);
    wr(16'h9B2A, 8'hC4);
    sweep_prg("R9", 3);
    sweep_chr("R9");
    sweep_nt("R9");

    // R10: strobe low does nothing
    @(negedge clk);
    cpu_wr_addr = 16'h8000; cpu_wr_data = 8'h00;
    repeat (3) @(negedge clk);
    cpu_wr_addr = 16'hE000; cpu_wr_data = 8'h02;
    repeat (3) @(negedge clk);
    sweep_prg("R10", 7);
    sweep_nt("R10");

    // R10: change visible right after the write edge
    @(negedge clk);
    cpu_rd_addr = 16'hA123;
    cpu_wr = 1'b1; cpu_wr_addr = 16'h8010; cpu_wr_data = 8'h42;
    #1;
    chk("R10", int'(prg_rom_addr), 32'hA3 * 32'h2000 + 32'h0123);
    @(posedge clk);
    #1;
    chk("R10", int'(prg_rom_addr), 32'h42 * 32'h2000 + 32'h0123);
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(16'h8010, 8'h42);

    // R1: reset after activity
    do_reset();
    sweep_prg("R1", 13);
    sweep_chr("R1");
    sweep_nt("R1");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule